// File: doc/BRIEF.md
# Sixteen-Lane Memory Request Coalescer

The block gathers one group of sixteen lane memory requests at a time: a per-lane active bit, a per-lane byte address and one element-size code shared by the group. It then decides whether the group can be served by a single aligned burst. A group qualifies when every active lane k addresses exactly element k of one region. The region is sixteen elements long and starts on a multiple of its own size. A qualifying group leaves as one transaction carrying the region base and the region byte count. Any other group leaves as one element-sized transaction per active lane, lowest lane first.

Both sides are valid/ready streams. The input accepts a group when `in_valid` and `in_ready` are both high at a clock edge. `in_ready` is high exactly when no transactions of an earlier group are still waiting, so a group can be accepted only once all of the previous group's transactions have been taken. On the output, a transaction is taken when `txn_valid` and `txn_ready` are both high at an edge. While `txn_ready` is low, the presented transaction is held unchanged. The downstream side may hold `txn_ready` low for any number of cycles.

Top module: `coal_unit`

## Requirements
- R1: `in_ready` is high when no transactions are pending and low from the cycle after a group with at least one active lane is accepted until the cycle after that group's last transaction is accepted; while `txn_valid` is high, `in_ready` is low.
- R2: Element-size code 0 selects 4-byte elements, code 1 selects 8-byte elements, and codes 2 and 3 select 16-byte elements; the region size is sixteen elements (64, 128 or 256 bytes).
- R3: A group coalesces only if, for every active lane k, the lane address equals B + k*E, where E is the element size and B is a multiple of the region size. B is taken from the lowest active lane j as that lane's address minus j*E. A coalesced group gives exactly one transaction with `txn_addr` = B, `txn_bytes` = region size and `txn_coalesced` = 1.
- R4: The address of an inactive lane has no effect on the decision or on any transaction.
- R5: A group that does not coalesce gives one transaction per active lane in ascending lane order, each with that lane's address, `txn_bytes` = E and `txn_coalesced` = 0.
- R6: A group with no active lanes is accepted, produces no transaction, and leaves `in_ready` high.
- R7: While `txn_valid` is high and `txn_ready` is low, `txn_valid`, `txn_addr`, `txn_bytes` and `txn_coalesced` keep their values into the next cycle.
- R8: The first transaction of an accepted non-empty group is valid in the cycle after acceptance, and each further split transaction is valid in the cycle after the previous one is accepted.
- R9: After reset, `txn_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A request group is presented |
| in_ready | output | 1 | The block can accept a group |
| lane_act | input | LANES | Active bit per lane, bit k for lane k |
| lane_addr | input | LANES*AW | Byte address per lane, lane k in bits [k*AW +: AW] |
| elem_code | input | 2 | Element size code (0:4, 1:8, 2 or 3:16 bytes) |
| txn_valid | output | 1 | A transaction is presented |
| txn_ready | input | 1 | Downstream takes the transaction |
| txn_addr | output | AW | Transaction start byte address |
| txn_bytes | output | $clog2(LANES*16)+1 | Transaction length in bytes |
| txn_coalesced | output | 1 | High when the transaction serves the whole group |

## Verification
Two events can fall in the same cycle: the downstream taking (or stalling) the final transaction of a group, and a new group already waiting on `in_valid`. The bench holds `in_valid` high with the next group while the previous group is still draining under a random `txn_ready`. A reference model with a queue of expected transactions judges the result on every clock. The new group must not be taken while any transaction is pending, and it must be taken in the first cycle `in_ready` returns, with its first transaction one cycle later. Stalls on the last beat are checked for a stable transaction and a low `in_ready`.

// File: rtl/coal_pkg.sv
package coal_pkg;
  // element size code to log2 of the element byte count
  function automatic int elem_shift(input logic [1:0] code);
    case (code)
      2'd0:    elem_shift = 2;
      2'd1:    elem_shift = 3;
      default: elem_shift = 4;
    endcase
  endfunction
endpackage

// File: rtl/coal_first.sv
// Lowest set bit finder: index of the lowest-numbered set bit of vec.
module coal_first #(
  parameter int N = 16,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  vec,
  output logic [IW-1:0] idx,
  output logic          any
);
  always_comb begin
    idx = '0;
    any = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) begin
        idx = IW'(i);
        any = 1'b1;
      end
    end
  end
endmodule

// File: rtl/coal_lane_match.sv
// One lane's test: inactive, or at element IDX of the reference lane's region.
module coal_lane_match #(
  parameter int AW    = 32,
  parameter int LANES = 16,
  parameter int IDX   = 0,
  localparam int LIDX = $clog2(LANES)
) (
  input  logic          act,
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] ref_addr,
  input  logic [1:0]    elem_code,
  output logic          ok
);
  import coal_pkg::*;

  int            esh;
  int            rsh;
  logic [AW-1:0] rmask;
  logic [AW-1:0] want_off;
  logic          off_ok;
  logic          tag_ok;

  always_comb begin
    esh      = elem_shift(elem_code);
    rsh      = esh + LIDX;
    rmask    = (AW'(1) << rsh) - AW'(1);
    want_off = AW'(IDX) << esh;
    off_ok   = (addr & rmask) == want_off;
    tag_ok   = (addr & ~rmask) == (ref_addr & ~rmask);
    ok       = !act || (off_ok && tag_ok);
  end
endmodule

// File: rtl/coal_unit.sv
// Group coalescer: one aligned burst when the pattern allows, else one per lane.
module coal_unit #(
  parameter int LANES = 16,
  parameter int AW    = 32,
  localparam int LIDX = $clog2(LANES),
  localparam int BW   = $clog2(LANES * 16) + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [LANES-1:0]    lane_act,
  input  logic [LANES*AW-1:0] lane_addr,
  input  logic [1:0]          elem_code,
  output logic                txn_valid,
  input  logic                txn_ready,
  output logic [AW-1:0]       txn_addr,
  output logic [BW-1:0]       txn_bytes,
  output logic                txn_coalesced
);
  import coal_pkg::*;

  // captured group
  logic                 busy;
  logic [LANES-1:0]     grp_act;
  logic [LANES-1:0]     pend;
  logic [AW-1:0]        grp_addr [LANES];
  logic [1:0]           grp_code;

  logic [LIDX-1:0]      ref_idx;
  logic                 ref_any;
  logic [LIDX-1:0]      nxt_idx;
  logic                 nxt_any;
  logic [AW-1:0]        ref_addr;
  logic [LANES-1:0]     lane_ok;
  logic                 coal;
  logic [LANES-1:0]     pend_after;
  logic                 accept_in;
  logic                 accept_out;

  coal_first #(.N(LANES)) u_ref (.vec(grp_act), .idx(ref_idx), .any(ref_any));
  coal_first #(.N(LANES)) u_nxt (.vec(pend),    .idx(nxt_idx), .any(nxt_any));

  assign ref_addr = grp_addr[ref_idx];

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    coal_lane_match #(.AW(AW), .LANES(LANES), .IDX(k)) u_match (
      .act       (grp_act[k]),
      .addr      (grp_addr[k]),
      .ref_addr  (ref_addr),
      .elem_code (grp_code),
      .ok        (lane_ok[k])
    );
  end

  assign coal = ref_any && (&lane_ok);

  // output transaction
  int            esh;
  int            rsh;
  logic [AW-1:0] rmask;

  always_comb begin
    esh   = elem_shift(grp_code);
    rsh   = esh + LIDX;
    rmask = (AW'(1) << rsh) - AW'(1);
    if (coal) begin
      txn_addr  = ref_addr & ~rmask;
      txn_bytes = BW'(1) << rsh;
    end else begin
      txn_addr  = grp_addr[nxt_idx];
      txn_bytes = BW'(1) << esh;
    end
    txn_coalesced = coal;
  end

  assign txn_valid  = busy;
  assign in_ready   = !busy;
  assign accept_in  = in_valid && in_ready;
  assign accept_out = busy && txn_ready;

  always_comb begin
    pend_after = pend;
    if (nxt_any) pend_after[nxt_idx] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      pend <= '0;
    end else if (accept_in) begin
      busy <= |lane_act;
      pend <= lane_act;
    end else if (accept_out) begin
      if (coal || pend_after == '0) begin
        busy <= 1'b0;
        pend <= '0;
      end else begin
        pend <= pend_after;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (accept_in) begin
      grp_act  <= lane_act;
      grp_code <= elem_code;
      for (int k = 0; k < LANES; k++) grp_addr[k] <= lane_addr[k*AW +: AW];
    end
  end
endmodule

// File: rtl/coal_unit_chk.sv
module coal_unit_chk #(
  parameter int LANES = 16,
  parameter int AW    = 32,
  localparam int BW   = $clog2(LANES * 16) + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [LANES-1:0] lane_act,
  input logic             txn_valid,
  input logic             txn_ready,
  input logic [AW-1:0]    txn_addr,
  input logic [BW-1:0]    txn_bytes,
  input logic             txn_coalesced
);
  AST_BUSY_BLOCKS_IN: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |-> !in_ready); // R1

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid && !txn_ready |=> txn_valid && $stable(txn_addr) &&
      $stable(txn_bytes) && $stable(txn_coalesced)); // R7

  AST_BURST_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid && txn_coalesced |->
      ((txn_addr & (AW'(txn_bytes) - AW'(1))) == '0) &&
      (txn_bytes >= BW'(LANES * 4)) && ($countones(txn_bytes) == 1)); // R3

  AST_BURST_ENDS_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid && txn_ready && txn_coalesced |=> in_ready); // R3

  AST_SPLIT_ONE_ELEM: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid && !txn_coalesced |->
      (txn_bytes <= BW'(16)) && (txn_bytes >= BW'(4)) &&
      ($countones(txn_bytes) == 1)); // R5

  AST_EMPTY_GROUP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && (lane_act == '0) |=> in_ready && !txn_valid); // R6

  AST_FIRST_TXN_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && (lane_act != '0) |=> txn_valid); // R8
endmodule

bind coal_unit coal_unit_chk #(.LANES(LANES), .AW(AW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .in_valid      (in_valid),
  .in_ready      (in_ready),
  .lane_act      (lane_act),
  .txn_valid     (txn_valid),
  .txn_ready     (txn_ready),
  .txn_addr      (txn_addr),
  .txn_bytes     (txn_bytes),
  .txn_coalesced (txn_coalesced)
);

// File: tb/coal_unit_bench.sv
module coal_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LANES = 16;
  localparam int AW    = 32;
  localparam int BW    = $clog2(LANES * 16) + 1;
  localparam int LIMIT = 100000;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                in_valid = 1'b0;
  logic                in_ready;
  logic [LANES-1:0]    lane_act = '0;
  logic [LANES*AW-1:0] lane_addr = '0;
  logic [1:0]          elem_code = '0;
  logic                txn_valid;
  logic                txn_ready = 1'b0;
  logic [AW-1:0]       txn_addr;
  logic [BW-1:0]       txn_bytes;
  logic                txn_coalesced;

  always #(CLK_PERIOD / 2) clk = ~clk;

  coal_unit #(.LANES(LANES), .AW(AW)) u_coal_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .lane_act(lane_act), .lane_addr(lane_addr), .elem_code(elem_code),
    .txn_valid(txn_valid), .txn_ready(txn_ready), .txn_addr(txn_addr),
    .txn_bytes(txn_bytes), .txn_coalesced(txn_coalesced));

  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;
  bit timed_out = 0;
  int ready_pct = 70;

  // expected transactions
  logic [31:0] q_addr [$];
  int          q_bytes [$];
  bit          q_coal [$];
  string       q_tag [$];

  // group waiting to be offered
  bit          have_grp = 0;
  logic [15:0] g_act;
  logic [31:0] g_addr [16];
  logic [1:0]  g_code;
  string       g_tag;
  string       in_tag = "R1";

  bit          prev_stall = 0;
  logic [31:0] prev_addr;
  logic [BW-1:0] prev_bytes;
  logic        prev_coal;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // reference: behavioural expansion of a group into expected transactions
  task automatic model_group();
    int esz, rsz, first;
    logic [31:0] base;
    bit ok;
    esz = (g_code == 2'd0) ? 4 : (g_code == 2'd1) ? 8 : 16;
    rsz = 16 * esz;
    first = -1;
    ok = 1;
    base = '0;
    for (int k = 0; k < 16; k++) begin
      if (g_act[k]) begin
        if (first < 0) begin
          first = k;
          base = g_addr[k] - 32'(k * esz);
          if (base % 32'(rsz) != 0) ok = 0;
        end
        if (g_addr[k] != base + 32'(k * esz)) ok = 0;
      end
    end
    if (first < 0) return;
    if (ok) begin
      q_addr.push_back(base); q_bytes.push_back(rsz);
      q_coal.push_back(1'b1); q_tag.push_back(g_tag);
    end else begin
      for (int k = 0; k < 16; k++) begin
        if (g_act[k]) begin
          q_addr.push_back(g_addr[k]); q_bytes.push_back(esz);
          q_coal.push_back(1'b0); q_tag.push_back(g_tag);
        end
      end
    end
  endtask

  // one clock: compare outputs, choose ready, offer input
  task automatic step();
    bit take;
    @(negedge clk);
    cycles++;
    if (cycles > LIMIT) begin
      if (!timed_out) chk(1'b0, "R8", "watchdog expired", 32'(cycles), 32'(LIMIT));
      timed_out = 1;
      return;
    end
    chk(in_ready == (q_addr.size() == 0), in_tag, "in_ready",
        32'(in_ready), 32'(q_addr.size() == 0));
    chk(txn_valid == (q_addr.size() != 0), "R8", "txn_valid",
        32'(txn_valid), 32'(q_addr.size() != 0));
    if (prev_stall) begin
      chk(txn_valid && txn_addr == prev_addr && txn_bytes == prev_bytes &&
          txn_coalesced == prev_coal, "R7", "held transaction",
          txn_addr, prev_addr);
    end
    take = ($urandom_range(99) < 32'(ready_pct));
    if (txn_valid && q_addr.size() != 0) begin
      chk(txn_addr == q_addr[0], q_tag[0], "txn_addr", txn_addr, q_addr[0]);
      chk(int'(txn_bytes) == q_bytes[0], q_tag[0], "txn_bytes",
          32'(txn_bytes), 32'(q_bytes[0]));
      chk(txn_coalesced == q_coal[0], q_tag[0], "txn_coalesced",
          32'(txn_coalesced), 32'(q_coal[0]));
      if (take) begin
        void'(q_addr.pop_front()); void'(q_bytes.pop_front());
        void'(q_coal.pop_front()); void'(q_tag.pop_front());
      end
    end
    txn_ready  = take;
    prev_stall = txn_valid && !take;
    prev_addr  = txn_addr;
    prev_bytes = txn_bytes;
    prev_coal  = txn_coalesced;
    in_tag = "R1";
    if (have_grp) begin
      in_valid  = 1'b1;
      lane_act  = g_act;
      elem_code = g_code;
      for (int k = 0; k < 16; k++) lane_addr[k*AW +: AW] = g_addr[k];
      if (in_ready) begin
        model_group();
        have_grp = 0;
        if (g_act == '0) in_tag = "R6";
      end
    end else begin
      in_valid = 1'b0;
    end
  endtask

  task automatic submit(input logic [15:0] act, input logic [1:0] code,
                        input string tag);
    g_act = act; g_code = code; g_tag = tag; have_grp = 1;
    while (have_grp && !timed_out) step();
  endtask

  task automatic pattern(input logic [31:0] base, input logic [1:0] code);
    int esz;
    esz = (code == 2'd0) ? 4 : (code == 2'd1) ? 8 : 16;
    for (int k = 0; k < 16; k++) g_addr[k] = base + 32'(k * esz);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    chk(txn_valid == 1'b0, "R9", "txn_valid in reset", 32'(txn_valid), 0);
    chk(in_ready == 1'b1, "R9", "in_ready in reset", 32'(in_ready), 1);
    rst_n = 1'b1;
    step();

    // R2: each size code, full aligned groups
    pattern(32'h0000_1000, 2'd0); submit(16'hFFFF, 2'd0, "R2");
    pattern(32'h0000_2080, 2'd1); submit(16'hFFFF, 2'd1, "R2");
    pattern(32'h0000_3100, 2'd2); submit(16'hFFFF, 2'd2, "R2");
    pattern(32'h0000_4200, 2'd3); submit(16'hFFFF, 2'd3, "R2");

    // R4: inactive lanes carry garbage; lane 0 inactive
    pattern(32'h0001_0040, 2'd0);
    g_addr[0] = 32'hDEAD_BEEF; g_addr[5] = 32'h1234_5677; g_addr[15] = 32'h0;
    submit(16'h7FDE, 2'd0, "R4");
    pattern(32'h0002_0000, 2'd1);
    for (int k = 0; k < 15; k++) g_addr[k] = 32'hFFFF_FFF1 - 32'(k);
    submit(16'h8000, 2'd1, "R4");

    // R3: misaligned base, whole pattern shifted by one element
    pattern(32'h0000_5004, 2'd0); submit(16'hFFFF, 2'd0, "R3");
    // R3: same region but two lanes swapped
    pattern(32'h0000_6000, 2'd2);
    g_addr[2] = 32'h0000_6030; g_addr[3] = 32'h0000_6020;
    submit(16'h000F, 2'd2, "R3");
    // R3: lane in a neighbouring region
    pattern(32'h0000_7000, 2'd0); g_addr[9] = 32'h0000_7064;
    submit(16'h0303, 2'd0, "R3");

    // R5: scattered addresses, sparse mask
    for (int k = 0; k < 16; k++) g_addr[k] = 32'h0009_0000 + 32'(k * 100);
    submit(16'hA5C3, 2'd1, "R5");

    // R6: empty group between two others
    submit(16'h0000, 2'd0, "R6");
    step();
    pattern(32'h0000_8000, 2'd0); submit(16'h0001, 2'd0, "R6");

    // R7: heavy back-pressure
    ready_pct = 20;
    for (int k = 0; k < 16; k++) g_addr[k] = 32'h000A_0000 + 32'(k * 36);
    submit(16'hFFFF, 2'd0, "R7");
    pattern(32'h000B_0000, 2'd1); submit(16'hFFFF, 2'd1, "R7");

    // R8: back-to-back groups, ready always high
    ready_pct = 100;
    pattern(32'h000C_0000, 2'd0); submit(16'hFFFF, 2'd0, "R8");
    for (int k = 0; k < 16; k++) g_addr[k] = 32'h000D_0000 + 32'(k * 8);
    submit(16'h0006, 2'd0, "R8");

    // random mix
    ready_pct = 60;
    for (int n = 0; n < 60 && !timed_out; n++) begin
      logic [1:0] c;
      c = 2'($urandom_range(3));
      pattern({$urandom_range(32'hFFFF), 8'h00}, c);
      if ($urandom_range(2) == 0) g_addr[$urandom_range(15)] = $urandom;
      submit(16'($urandom), c, "R5");
    end

    while (q_addr.size() != 0 && !timed_out) step();
    repeat (3) step();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule